// File: doc/BRIEF.md
# Read-Through Level Fill Controller

This block manages one level of a multi-level storage hierarchy whose levels all listen to one shared broadcast bus. When some lower level answers a miss, it drives its whole transfer unit onto the bus, one word per beat, each beat tagged with the word's address. Every level above the source watches the same broadcast. Each one keeps only the aligned slice of its own unit size that holds the requested address. A fill that would otherwise pass through each level in turn therefore completes in a single broadcast.

The level holds a direct-mapped array of slots. Each slot holds one aligned unit of 2^UNIT_LOG2 words and has a tag and a valid bit. A request from above is looked up in the same cycle. A miss while the level is idle starts a fill and raises busy until the fill ends. A level placed directly above the source sets `full_capture_i` and stores every beat of the broadcast. A level higher up stores only the beats that fall inside its own requested block. A missing or disabled level in between changes nothing for the levels above it, because they select purely by address alignment.

Top module: `rt_fill_ctrl`

## Requirements
- R1: After reset every slot is invalid, `busy_o` and `fill_done_o` are low, and no request hits.
- R2: A request that misses while the level is idle starts a fill. `busy_o` is high from the next cycle, and the slot `req_addr_i[UNIT_LOG2+SLOT_LOG2-1:UNIT_LOG2]` is marked invalid.
- R3: During a fill, a beat whose address has the same block number (`addr >> UNIT_LOG2`) as the request is written at array index `addr[UNIT_LOG2+SLOT_LOG2-1:0]`. The slot tag is `addr >> (UNIT_LOG2+SLOT_LOG2)`.
- R4: When `full_capture_i` is low, a beat outside the requested block, or any beat while no fill is running, leaves the stored data and tags unchanged.
- R5: When the 2^UNIT_LOG2-th word of the block has been captured, the slot becomes valid and `busy_o` falls. `fill_done_o` is high for exactly the one following cycle.
- R6: A slot with a partial fill never reports a hit. A valid bit rises only together with `fill_done_o`.
- R7: If `bus_last_i` arrives before the block is complete, the fill is abandoned. `busy_o` falls and the slot stays invalid.
- R8: A request that arrives while `busy_o` is high is not accepted. It changes neither the fill target nor any other slot.
- R9: With `full_capture_i` high, every beat is captured. The block to fill is taken from the address of the first beat.
- R10: `hit_o` and `hit_data_o` are combinational lookups of `req_addr_i` against the slot's tag and valid bit.
- R11: Broadcasts 2, 4 or 8 times the level's unit are all served by the same slice selection, with no second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request from the level above is present |
| req_addr_i | input | ADDR_W | Requested word address |
| bus_valid_i | input | 1 | Broadcast beat present |
| bus_addr_i | input | ADDR_W | Address of the broadcast word |
| bus_data_i | input | DATA_W | Broadcast word |
| bus_last_i | input | 1 | Final beat of the broadcast |
| full_capture_i | input | 1 | This level sits directly above the source and stores every beat |
| hit_o | output | 1 | Request address held in a valid slot |
| hit_data_o | output | DATA_W | Word at the request address |
| busy_o | output | 1 | Fill in progress; new requests are not accepted |
| fill_done_o | output | 1 | One-cycle pulse after a completed fill |
| tag_valid_o | output | 2^SLOT_LOG2 | Valid bit of each slot |

## Verification
The bench builds the level with its default parameters: a 12-bit address, 16-bit words, 4-word units and 4 slots. With only 4 slots, eviction and slot reuse are reached with a few addresses. With 4-word units, broadcasts of 8, 16 and 32 words give the 2x, 4x and 8x ratios, and the 8x case stands in for intermediate levels that are absent. Short broadcasts that end early and broadcasts that miss the requested block reach the abort path. An idle broadcast and a full-capture broadcast exercise the ignore rule and the opposite, store-everything case.

// File: rtl/rt_fill_pkg.sv
package rt_fill_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/rt_fill_tracker.sv
module rt_fill_tracker import rt_fill_pkg::*; #(
  parameter int BLK_W     = 10,
  parameter int UNIT_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_accept_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             bus_valid_i,
  input  logic [BLK_W-1:0] bus_blk_i,
  input  logic             bus_last_i,
  input  logic             full_capture_i,
  output logic             busy_o,
  output logic             take_o,
  output logic [BLK_W-1:0] eff_blk_o,
  output logic             complete_o,
  output logic             done_o
);
  localparam int CNT_W = UNIT_LOG2 + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((1 << UNIT_LOG2) - 1);

  fill_state_e      state_q;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_blk, abort;

  always_comb begin
    in_blk     = (bus_blk_i == blk_q);
    take_o     = bus_valid_i && (full_capture_i || (state_q == FILL_RUN && in_blk));
    // full capture: block follows the first beat of the broadcast
    eff_blk_o  = (full_capture_i && cnt_q == '0) ? bus_blk_i : blk_q;
    complete_o = take_o && (cnt_q == LAST_CNT);
    abort      = bus_valid_i && bus_last_i && !complete_o && (state_q == FILL_RUN || take_o);
    busy_o     = (state_q == FILL_RUN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      blk_q   <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= complete_o;
      if (req_accept_i) begin
        state_q <= FILL_RUN;
        blk_q   <= req_blk_i;
        cnt_q   <= '0;
      end else if (complete_o || abort) begin
        state_q <= FILL_IDLE;
        cnt_q   <= '0;
      end else if (take_o) begin
        state_q <= FILL_RUN;
        blk_q   <= eff_blk_o;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_tag_store.sv
module rt_tag_store #(
  parameter int TAG_W     = 8,
  parameter int SLOT_LOG2 = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic [SLOT_LOG2-1:0]   clear_slot_i,
  input  logic                   take_i,
  input  logic                   complete_i,
  input  logic [SLOT_LOG2-1:0]   fill_slot_i,
  input  logic [TAG_W-1:0]       fill_tag_i,
  input  logic                   look_valid_i,
  input  logic [SLOT_LOG2-1:0]   look_slot_i,
  input  logic [TAG_W-1:0]       look_tag_i,
  output logic [(1<<SLOT_LOG2)-1:0] valid_o,
  output logic                   hit_o
);
  localparam int SLOTS = 1 << SLOT_LOG2;

  logic [TAG_W-1:0] tag_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_here, clr_here;
    assign hit_here = (fill_slot_i == SLOT_LOG2'(s)) && take_i;
    assign clr_here = (clear_slot_i == SLOT_LOG2'(s)) && clear_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[s] <= 1'b0;
        tag_q[s]   <= '0;
      end else if (hit_here && complete_i) begin
        valid_o[s] <= 1'b1;
        tag_q[s]   <= fill_tag_i;
      end else if (hit_here || clr_here) begin
        valid_o[s] <= 1'b0;
      end
    end
  end

  assign hit_o = look_valid_i && valid_o[look_slot_i] && (tag_q[look_slot_i] == look_tag_i);
endmodule

// File: rtl/rt_word_array.sv
module rt_word_array #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rt_fill_ctrl.sv
module rt_fill_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int UNIT_LOG2 = 2,
  parameter int SLOT_LOG2 = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      bus_valid_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_data_i,
  input  logic                      bus_last_i,
  input  logic                      full_capture_i,
  output logic                      hit_o,
  output logic [DATA_W-1:0]         hit_data_o,
  output logic                      busy_o,
  output logic                      fill_done_o,
  output logic [(1<<SLOT_LOG2)-1:0] tag_valid_o
);
  localparam int BLK_W = ADDR_W - UNIT_LOG2;
  localparam int TAG_W = BLK_W - SLOT_LOG2;
  localparam int IDX_W = UNIT_LOG2 + SLOT_LOG2;

  logic [BLK_W-1:0] req_blk, bus_blk, eff_blk;
  logic             accept, take, complete;

  assign req_blk = req_addr_i[ADDR_W-1:UNIT_LOG2];
  assign bus_blk = bus_addr_i[ADDR_W-1:UNIT_LOG2];
  assign accept  = req_valid_i && !hit_o && !busy_o;

  rt_fill_tracker #(
    .BLK_W    (BLK_W),
    .UNIT_LOG2(UNIT_LOG2)
  ) u_tracker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_accept_i  (accept),
    .req_blk_i     (req_blk),
    .bus_valid_i   (bus_valid_i),
    .bus_blk_i     (bus_blk),
    .bus_last_i    (bus_last_i),
    .full_capture_i(full_capture_i),
    .busy_o        (busy_o),
    .take_o        (take),
    .eff_blk_o     (eff_blk),
    .complete_o    (complete),
    .done_o        (fill_done_o)
  );

  rt_tag_store #(
    .TAG_W    (TAG_W),
    .SLOT_LOG2(SLOT_LOG2)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .clear_slot_i(req_blk[SLOT_LOG2-1:0]),
    .take_i      (take),
    .complete_i  (complete),
    .fill_slot_i (eff_blk[SLOT_LOG2-1:0]),
    .fill_tag_i  (eff_blk[BLK_W-1:SLOT_LOG2]),
    .look_valid_i(req_valid_i),
    .look_slot_i (req_blk[SLOT_LOG2-1:0]),
    .look_tag_i  (req_blk[BLK_W-1:SLOT_LOG2]),
    .valid_o     (tag_valid_o),
    .hit_o       (hit_o)
  );

  rt_word_array #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_words (
    .clk_i  (clk_i),
    .we_i   (take),
    .waddr_i(bus_addr_i[IDX_W-1:0]),
    .wdata_i(bus_data_i),
    .raddr_i(req_addr_i[IDX_W-1:0]),
    .rdata_o(hit_data_o)
  );
endmodule

// File: rtl/rt_fill_ctrl_chk.sv
module rt_fill_ctrl_chk #(
  parameter int SLOTS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             bus_valid_i,
  input logic             bus_last_i,
  input logic             full_capture_i,
  input logic             busy_o,
  input logic             fill_done_o,
  input logic [SLOTS-1:0] tag_valid_o
);
  // R5
  a_r5_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> !busy_o);
  // R5
  a_r5_done_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> $past(bus_valid_i));
  // R6
  a_r6_valid_rises_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tag_valid_o & ~$past(tag_valid_o)) != '0) |-> fill_done_o);
  // R2
  a_r2_busy_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(req_valid_i) || ($past(bus_valid_i) && $past(full_capture_i))));
  // R7
  a_r7_last_ends_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bus_valid_i && bus_last_i) |=> !busy_o);
  // R4
  a_r4_idle_beats_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !full_capture_i && !req_valid_i) |=> ($stable(tag_valid_o) && !busy_o));
endmodule

bind rt_fill_ctrl rt_fill_ctrl_chk #(.SLOTS(1 << SLOT_LOG2)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .bus_valid_i   (bus_valid_i),
  .bus_last_i    (bus_last_i),
  .full_capture_i(full_capture_i),
  .busy_o        (busy_o),
  .fill_done_o   (fill_done_o),
  .tag_valid_o   (tag_valid_o)
);

// File: tb/rt_fill_ctrl_bench.sv
`timescale 1ns/1ps
module rt_fill_ctrl_bench;
  localparam int AW = 12, DW = 16, UL = 2, SL = 2;
  localparam int UNIT = 1 << UL, SLOTS = 1 << SL, WORDS = UNIT * SLOTS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rv = 0, bv = 0, bl = 0, fc = 0;
  logic [AW-1:0] ra = '0, ba = '0;
  logic [DW-1:0] bd = '0;
  logic hit, busy, done;
  logic [DW-1:0] hdata;
  logic [SLOTS-1:0] tvalid;

  always #10 clk = ~clk;

  rt_fill_ctrl u_rt_fill_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_addr_i(ra),
    .bus_valid_i(bv), .bus_addr_i(ba), .bus_data_i(bd), .bus_last_i(bl),
    .full_capture_i(fc), .hit_o(hit), .hit_data_o(hdata), .busy_o(busy),
    .fill_done_o(done), .tag_valid_o(tvalid)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_valid [SLOTS];
  int m_tag [SLOTS];
  int m_mem [WORDS];
  bit m_busy = 0, m_done = 0;
  int m_blk = 0, m_cnt = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit m_hit(input int a);
    int blk = a >> UL;
    return rv && m_valid[blk % SLOTS] && m_tag[blk % SLOTS] == (blk >> SL);
  endfunction

  function automatic int m_vec();
    int v = 0;
    for (int s = 0; s < SLOTS; s++) if (m_valid[s]) v |= (1 << s);
    return v;
  endfunction

  task automatic drive(input bit r, input int a, input bit b, input int ad, input int d,
                       input bit l, input bit f);
    rv = r; ra = AW'(a); bv = b; ba = AW'(ad); bd = DW'(d); bl = l; fc = f;
  endtask

  task automatic tick();
    bit eh, take, comp, abrt;
    int bblk, eff;
    #1;
    eh = m_hit(int'(ra));
    chk(hit == eh, "R10/R6 hit", hit, eh);
    chk(busy == m_busy, "R2/R8 busy", busy, m_busy);
    chk(done == m_done, "R5 fill_done", done, m_done);
    chk(int'(tvalid) == m_vec(), "R3/R7 tag_valid", tvalid, m_vec());
    if (eh) chk(int'(hdata) == m_mem[int'(ra) % WORDS], "R3/R4 hit_data", hdata, m_mem[int'(ra) % WORDS]);
    @(posedge clk);
    bblk = int'(ba) >> UL;
    take = bv && (fc || (m_busy && bblk == m_blk));
    eff  = (fc && m_cnt == 0) ? bblk : m_blk;
    comp = take && (m_cnt == UNIT - 1);
    abrt = bv && bl && !comp && (m_busy || take);
    m_done = comp;
    if (rv && !eh && !m_busy) begin
      m_busy = 1; m_blk = int'(ra) >> UL; m_cnt = 0; m_valid[m_blk % SLOTS] = 0;
    end else if (comp || abrt) begin
      m_busy = 0; m_cnt = 0;
    end else if (take) begin
      m_busy = 1; m_blk = eff; m_cnt++;
    end
    if (take) begin
      m_mem[int'(ba) % WORDS] = int'(bd);
      if (comp) begin m_valid[eff % SLOTS] = 1; m_tag[eff % SLOTS] = eff >> SL; end
      else m_valid[eff % SLOTS] = 0;
    end
    @(negedge clk);
  endtask

  task automatic request(input int a);
    drive(1, a, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic broadcast(input int base, input int n, input int salt, input bit f);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 1, base + i, (base + i) ^ salt, i == n - 1, f); tick();
    end
    drive(0, 0, 0, 0, 0, 0, 0); tick();
  endtask

  task automatic look(input int a, input bit eh, input int ed, input string what);
    drive(1, a, 0, 0, 0, 0, 0); #2;
    chk(hit == eh, what, hit, eh);
    if (eh) chk(hdata == DW'(ed), what, hdata, ed);
    tick(); drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin m_valid[s] = 0; m_tag[s] = 0; end
    for (int w = 0; w < WORDS; w++) m_mem[w] = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(tvalid == '0 && !busy && !done && !hit, "R1 reset state", {busy, done, tvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 / R11: 4x broadcast
    request('h014);
    chk(busy == 1'b1, "R2 busy after miss", busy, 1);
    broadcast('h010, 16, 'h1100, 0);
    look('h014, 1, 'h014 ^ 'h1100, "R3 word 0");
    look('h017, 1, 'h017 ^ 'h1100, "R3 word 3");

    // R11: 2x and 8x broadcasts
    request('h028);
    broadcast('h028, 8, 'h2200, 0);
    look('h02A, 1, 'h02A ^ 'h2200, "R11 2x slice");
    request('h0BC);
    broadcast('h0A0, 32, 'h3300, 0);
    look('h0BD, 1, 'h0BD ^ 'h3300, "R11 8x slice");

    // R4: idle broadcast ignored
    broadcast('h010, 16, 'h4400, 0);
    look('h015, 1, 'h015 ^ 'h1100, "R4 idle beats ignored");

    // R8: request while busy not accepted
    request('h104);
    request('h208);
    chk(tvalid[2] == 1'b1, "R8 other slot untouched", tvalid[2], 1);
    broadcast('h100, 16, 'h5500, 0);
    look('h028, 1, 'h028 ^ 'h2200, "R8 slot 2 kept");
    look('h106, 1, 'h106 ^ 'h5500, "R8 original target filled");

    // R6 / R7: partial fill then early last
    request('h0C4);
    drive(0, 0, 1, 'h0C4, 'h0C4 ^ 'h6600, 0, 0); tick();
    look('h0C4, 0, 0, "R6 partial no hit");
    drive(0, 0, 1, 'h0C5, 'h0C5 ^ 'h6600, 1, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    chk(tvalid[1] == 1'b0 && !busy, "R7 abort partial", {busy, tvalid[1]}, 0);

    // R7: broadcast that misses the block
    request('h0C4);
    broadcast('h0D0, 16, 'h7700, 0);
    chk(!busy && tvalid[1] == 1'b0, "R7 abort outside block", {busy, tvalid[1]}, 0);

    // R9: full capture without a request
    broadcast('h040, 4, 'h8800, 1);
    look('h042, 1, 'h042 ^ 'h8800, "R9 full capture");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule